// File: doc/BRIEF.md
# Two-Register Indexed Access Bridge

This block sits between a host with a narrow address window and a controller that decodes a 28-bit command address. The host first stores a complete control word in an index register, then touches a data register. Each data access is sent downstream with the stored control word as its address. Because the index register keeps its value, a run of data reads or writes all go to the same control address without storing it again. A strap input turns on a pass-through mode instead. In that mode every host access goes downstream unchanged, using the host's own address, so the host needs the full 28-bit region.

The stored control word is also decoded onto plain outputs: a 2-bit map selector, a 2-bit bank number and the low field under them. Map 1 and map 2 carry a page address in the low field. Map 3 carries raw controller cycles, with the cycle kind in the two lowest bits.

Host requests use valid/ready. The bridge takes one request at a time and keeps `host_req_ready` low while a read is in flight. A read response stays on `host_rsp_valid` and `host_rsp_data` until the host raises `host_rsp_ready`. Data writes are posted: the bridge does not wait for the downstream side. The downstream request is a single-cycle strobe, and a downstream read completes when `dn_rsp_valid` is high for one cycle.

Top module: `winbr_top`

## Requirements
- R1: After reset:
  - the index register is zero;
  - `dn_valid` and `host_rsp_valid` are low;
  - `host_req_ready` is high.
- R2: In indexed mode, a host write whose address low byte is 0x00 loads bits 27:0 of the write data into the index register. A host read at low byte 0x00 returns the index register, zero-extended, one cycle after acceptance.
- R3: In indexed mode, a host write at low byte 0x10 makes `dn_valid` high for exactly one cycle, in the cycle after acceptance. In that cycle `dn_write` is 1, `dn_addr` is the index register and `dn_wdata` is the host write data.
- R4: In indexed mode, a host read at low byte 0x10 behaves as follows:
  - in the cycle after acceptance, it makes `dn_valid` high for one cycle with `dn_write` 0 and `dn_addr` equal to the index register;
  - `host_rsp_valid` rises in the cycle after the one where `dn_rsp_valid` is sampled high, carrying `dn_rsp_data`;
  - the response is held stable while `host_rsp_ready` is low;
  - `host_req_ready` stays low until the response is taken.
- R5: The index register keeps its value across any number of data-register accesses, so consecutive data accesses use the same downstream address.
- R6: When `direct_mode` is 1, every host access is forwarded with `dn_addr` equal to the host address. A write whose address low byte is 0x00 goes downstream and does not change the index register.
- R7: `ctl_map` is index bits 27:26, where 0 is buffer access, 1 is page I/O, 2 is the command plane and 3 is raw cycles. `ctl_bank` is bits 25:24, selecting one of four banks. `ctl_low` is bits 23:0.
- R8: `ctl_raw` is 1 exactly when the map is 3; its cycle kind is `ctl_low[1:0]`, where 0 is command, 1 is address and 2 is data. `ctl_page_vld` is 1 exactly when the map is 1 or 2.
- R9: In indexed mode, host accesses at any other low byte do not pulse `dn_valid`. Writes there leave the index register unchanged. Reads there return zero one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| direct_mode | input | 1 | Strap: 1 forwards host addresses unchanged |
| host_req_valid | input | 1 | Host request valid |
| host_req_ready | output | 1 | Bridge can accept a request |
| host_req_write | input | 1 | 1 write, 0 read |
| host_req_addr | input | 28 | Host byte address |
| host_req_wdata | input | 32 | Host write data |
| host_rsp_valid | output | 1 | Read response valid |
| host_rsp_ready | input | 1 | Host takes the response |
| host_rsp_data | output | 32 | Read response data |
| dn_valid | output | 1 | One-cycle downstream request strobe |
| dn_write | output | 1 | Downstream direction, 1 write |
| dn_addr | output | 28 | Downstream control address |
| dn_wdata | output | 32 | Downstream write data |
| dn_rsp_valid | input | 1 | Downstream read data valid |
| dn_rsp_data | input | 32 | Downstream read data |
| ctl_map | output | 2 | Decoded map selector |
| ctl_bank | output | 2 | Decoded bank number |
| ctl_low | output | 24 | Page address or cycle kind field |
| ctl_raw | output | 1 | Map is raw cycles |
| ctl_page_vld | output | 1 | Low field is a page address |

## Verification
Every result is due at a fixed distance from an edge where a handshake completes:
- the downstream strobe, the index update and the decoded fields appear one cycle after the host request is accepted;
- a local read response also appears one cycle after acceptance;
- a forwarded read response appears one cycle after the downstream response strobe.

The bench drives and samples on the falling edge. After each accepting edge it samples in exactly those cycles. It also samples the following cycle to confirm that the strobe has dropped and that a held response has not moved. Downstream latency and host response hold time are varied, so the waiting cycles of R4 are exercised against expected values computed by bench functions.

// File: rtl/winbr_pkg.sv
package winbr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } winbr_state_e;

  typedef enum logic [1:0] {
    MAP_BUF = 2'd0,
    MAP_PIO = 2'd1,
    MAP_CMD = 2'd2,
    MAP_RAW = 2'd3
  } winbr_map_e;

  localparam int SEL_W = 2;
endpackage

// File: rtl/winbr_index.sv
module winbr_index
  import winbr_pkg::*;
#(
  parameter int ADDR_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] idx_o,
  output logic [SEL_W-1:0]  map_o,
  output logic [SEL_W-1:0]  bank_o,
  output logic [ADDR_W-2*SEL_W-1:0] low_o,
  output logic              raw_o,
  output logic              page_vld_o
);
  localparam int MAP_LSB  = ADDR_W - SEL_W;
  localparam int BANK_LSB = ADDR_W - 2*SEL_W;

  logic [ADDR_W-1:0] idx_q;
  winbr_map_e        map_e;

  always_ff @(posedge clk) begin
    if (!rst_n)    idx_q <= '0;
    else if (we_i) idx_q <= wdata_i;
  end

  assign idx_o      = idx_q;
  assign map_o      = idx_q[ADDR_W-1:MAP_LSB];
  assign bank_o     = idx_q[MAP_LSB-1:BANK_LSB];
  assign low_o      = idx_q[BANK_LSB-1:0];
  assign map_e      = winbr_map_e'(map_o);
  assign raw_o      = (map_e == MAP_RAW);
  assign page_vld_o = (map_e == MAP_PIO) || (map_e == MAP_CMD);

  // R5
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(idx_o));

  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({raw_o, page_vld_o}));
endmodule

// File: rtl/winbr_seq.sv
module winbr_seq
  import winbr_pkg::*;
#(
  parameter int ADDR_W  = 28,
  parameter int DATA_W  = 32,
  parameter int OFF_W   = 8,
  parameter int IDX_OFF = 0,
  parameter int DAT_OFF = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              direct_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              dn_valid_o,
  output logic              dn_write_o,
  output logic [ADDR_W-1:0] dn_addr_o,
  output logic [DATA_W-1:0] dn_wdata_o,
  input  logic              dn_rsp_valid_i,
  input  logic [DATA_W-1:0] dn_rsp_data_i,
  input  logic [ADDR_W-1:0] idx_i,
  output logic              idx_we_o
);
  localparam logic [OFF_W-1:0] IDX_SEL = OFF_W'(IDX_OFF);
  localparam logic [OFF_W-1:0] DAT_SEL = OFF_W'(DAT_OFF);

  winbr_state_e      st_q;
  logic              take, hit_idx, hit_dat, fwd;
  logic [OFF_W-1:0]  off;
  logic              dn_valid_q, dn_write_q;
  logic [ADDR_W-1:0] dn_addr_q;
  logic [DATA_W-1:0] dn_wdata_q, rdata_q;

  assign off         = req_addr_i[OFF_W-1:0];
  assign hit_idx     = !direct_i && (off == IDX_SEL);
  assign hit_dat     = !direct_i && (off == DAT_SEL);
  assign fwd         = direct_i || hit_dat;
  assign req_ready_o = (st_q == ST_IDLE);
  assign take        = req_valid_i && req_ready_o;
  assign idx_we_o    = take && req_write_i && hit_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      dn_valid_q <= 1'b0;
      dn_write_q <= 1'b0;
      dn_addr_q  <= '0;
      dn_wdata_q <= '0;
      rdata_q    <= '0;
    end else begin
      dn_valid_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (take) begin
            if (fwd) begin
              dn_valid_q <= 1'b1;
              dn_write_q <= req_write_i;
              dn_addr_q  <= direct_i ? req_addr_i : idx_i;
              dn_wdata_q <= req_wdata_i;
              if (!req_write_i) st_q <= ST_WAIT;
            end else if (!req_write_i) begin
              rdata_q <= hit_idx ? DATA_W'(idx_i) : '0;
              st_q    <= ST_RESP;
            end
          end
        end
        ST_WAIT: begin
          if (dn_rsp_valid_i) begin
            rdata_q <= dn_rsp_data_i;
            st_q    <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (rsp_ready_i) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid_o = (st_q == ST_RESP);
  assign rsp_data_o  = rdata_q;
  assign dn_valid_o  = dn_valid_q;
  assign dn_write_o  = dn_write_q;
  assign dn_addr_o   = dn_addr_q;
  assign dn_wdata_o  = dn_wdata_q;

  // R3
  dn_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid_o |-> $past(take));

  // R4
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_data_o));

  // R6
  direct_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid_o && $past(direct_i) |-> dn_addr_o == $past(req_addr_i));
endmodule

// File: rtl/winbr_top.sv
module winbr_top
  import winbr_pkg::*;
#(
  parameter int ADDR_W  = 28,
  parameter int DATA_W  = 32,
  parameter int OFF_W   = 8,
  parameter int IDX_OFF = 0,
  parameter int DAT_OFF = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    direct_mode,
  input  logic                    host_req_valid,
  output logic                    host_req_ready,
  input  logic                    host_req_write,
  input  logic [ADDR_W-1:0]       host_req_addr,
  input  logic [DATA_W-1:0]       host_req_wdata,
  output logic                    host_rsp_valid,
  input  logic                    host_rsp_ready,
  output logic [DATA_W-1:0]       host_rsp_data,
  output logic                    dn_valid,
  output logic                    dn_write,
  output logic [ADDR_W-1:0]       dn_addr,
  output logic [DATA_W-1:0]       dn_wdata,
  input  logic                    dn_rsp_valid,
  input  logic [DATA_W-1:0]       dn_rsp_data,
  output logic [SEL_W-1:0]        ctl_map,
  output logic [SEL_W-1:0]        ctl_bank,
  output logic [ADDR_W-2*SEL_W-1:0] ctl_low,
  output logic                    ctl_raw,
  output logic                    ctl_page_vld
);
  logic [ADDR_W-1:0] idx;
  logic              idx_we;

  winbr_index #(.ADDR_W(ADDR_W)) u_index (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_i       (idx_we),
    .wdata_i    (host_req_wdata[ADDR_W-1:0]),
    .idx_o      (idx),
    .map_o      (ctl_map),
    .bank_o     (ctl_bank),
    .low_o      (ctl_low),
    .raw_o      (ctl_raw),
    .page_vld_o (ctl_page_vld)
  );

  winbr_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W),
    .IDX_OFF(IDX_OFF), .DAT_OFF(DAT_OFF)
  ) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .direct_i       (direct_mode),
    .req_valid_i    (host_req_valid),
    .req_ready_o    (host_req_ready),
    .req_write_i    (host_req_write),
    .req_addr_i     (host_req_addr),
    .req_wdata_i    (host_req_wdata),
    .rsp_valid_o    (host_rsp_valid),
    .rsp_ready_i    (host_rsp_ready),
    .rsp_data_o     (host_rsp_data),
    .dn_valid_o     (dn_valid),
    .dn_write_o     (dn_write),
    .dn_addr_o      (dn_addr),
    .dn_wdata_o     (dn_wdata),
    .dn_rsp_valid_i (dn_rsp_valid),
    .dn_rsp_data_i  (dn_rsp_data),
    .idx_i          (idx),
    .idx_we_o       (idx_we)
  );
endmodule

// File: tb/winbr_top_test.sv
module winbr_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        direct_mode = 1'b0;
  logic        host_req_valid = 1'b0;
  logic        host_req_ready;
  logic        host_req_write = 1'b0;
  logic [27:0] host_req_addr = '0;
  logic [31:0] host_req_wdata = '0;
  logic        host_rsp_valid;
  logic        host_rsp_ready = 1'b0;
  logic [31:0] host_rsp_data;
  logic        dn_valid, dn_write;
  logic [27:0] dn_addr;
  logic [31:0] dn_wdata;
  logic        dn_rsp_valid = 1'b0;
  logic [31:0] dn_rsp_data = '0;
  logic [1:0]  ctl_map, ctl_bank;
  logic [23:0] ctl_low;
  logic        ctl_raw, ctl_page_vld;

  int n_chk = 0;
  int n_bad = 0;
  logic [27:0] idx_m = '0;

  always #10 clk = ~clk;

  winbr_top uut (
    .clk(clk), .rst_n(rst_n), .direct_mode(direct_mode),
    .host_req_valid(host_req_valid), .host_req_ready(host_req_ready),
    .host_req_write(host_req_write), .host_req_addr(host_req_addr),
    .host_req_wdata(host_req_wdata), .host_rsp_valid(host_rsp_valid),
    .host_rsp_ready(host_rsp_ready), .host_rsp_data(host_rsp_data),
    .dn_valid(dn_valid), .dn_write(dn_write), .dn_addr(dn_addr),
    .dn_wdata(dn_wdata), .dn_rsp_valid(dn_rsp_valid), .dn_rsp_data(dn_rsp_data),
    .ctl_map(ctl_map), .ctl_bank(ctl_bank), .ctl_low(ctl_low),
    .ctl_raw(ctl_raw), .ctl_page_vld(ctl_page_vld)
  );

  function automatic logic [31:0] dn_fn(input logic [27:0] a);
    return {4'hA, a} ^ 32'h0135_7BDF;
  endfunction

  function automatic logic is_fwd(input logic [27:0] a);
    return direct_mode || (a[7:0] == 8'h10);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_ctl();
    logic [1:0] m;
    m = idx_m[27:26];
    check("R7 map", 32'(ctl_map), 32'(m));
    check("R7 bank", 32'(ctl_bank), 32'(idx_m[25:24]));
    check("R7 low", 32'(ctl_low), 32'(idx_m[23:0]));
    check("R8 raw", 32'(ctl_raw), 32'(m == 2'd3));
    check("R8 page_vld", 32'(ctl_page_vld), 32'(m == 2'd1 || m == 2'd2));
  endtask

  task automatic host_wr(input logic [27:0] a, input logic [31:0] d);
    logic f, li;
    f  = is_fwd(a);
    li = !direct_mode && a[7:0] == 8'h00;
    host_req_valid = 1'b1; host_req_write = 1'b1;
    host_req_addr = a; host_req_wdata = d;
    @(posedge clk); @(negedge clk);
    host_req_valid = 1'b0;
    if (li) idx_m = d[27:0];
    if (f) begin
      check("R3 dn_valid", 32'(dn_valid), 32'd1);
      check("R3 dn_write", 32'(dn_write), 32'd1);
      check(direct_mode ? "R6 dn_addr" : "R3 dn_addr", 32'(dn_addr),
            32'(direct_mode ? a : idx_m));
      check("R3 dn_wdata", dn_wdata, d);
    end else begin
      check("R9 no strobe on write", 32'(dn_valid), 32'd0);
    end
    chk_ctl();
    @(negedge clk);
    check("R3 single pulse", 32'(dn_valid), 32'd0);
  endtask

  task automatic host_rd(input logic [27:0] a, input int lat, input int hold);
    logic f;
    logic [31:0] exp_d;
    f = is_fwd(a);
    host_req_valid = 1'b1; host_req_write = 1'b0; host_req_addr = a;
    @(posedge clk); @(negedge clk);
    host_req_valid = 1'b0;
    if (f) begin
      exp_d = dn_fn(direct_mode ? a : idx_m);
      check("R4 dn_valid", 32'(dn_valid), 32'd1);
      check("R4 dn_write", 32'(dn_write), 32'd0);
      check(direct_mode ? "R6 dn_addr" : "R4 dn_addr", 32'(dn_addr),
            32'(direct_mode ? a : idx_m));
      for (int k = 0; k < lat; k++) begin
        check("R4 no early rsp", 32'(host_rsp_valid), 32'd0);
        check("R4 busy", 32'(host_req_ready), 32'd0);
        @(negedge clk);
      end
      dn_rsp_valid = 1'b1; dn_rsp_data = exp_d;
      @(negedge clk);
      dn_rsp_valid = 1'b0; dn_rsp_data = 32'hDEAD_BEEF;
      check("R4 rsp_valid", 32'(host_rsp_valid), 32'd1);
      check("R4 rsp_data", host_rsp_data, exp_d);
    end else begin
      exp_d = (a[7:0] == 8'h00) ? 32'(idx_m) : 32'd0;
      check("R9 no strobe on read", 32'(dn_valid), 32'd0);
      check(a[7:0] == 8'h00 ? "R2 rsp_valid" : "R9 rsp_valid", 32'(host_rsp_valid), 32'd1);
      check(a[7:0] == 8'h00 ? "R2 readback" : "R9 zero read", host_rsp_data, exp_d);
    end
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check("R4 held valid", 32'(host_rsp_valid), 32'd1);
      check("R4 held data", host_rsp_data, exp_d);
      check("R4 held busy", 32'(host_req_ready), 32'd0);
    end
    host_rsp_ready = 1'b1;
    @(negedge clk);
    host_rsp_ready = 1'b0;
    check("R4 rsp taken", 32'(host_rsp_valid), 32'd0);
    check("R4 ready again", 32'(host_req_ready), 32'd1);
    chk_ctl();
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R4 actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 dn_valid", 32'(dn_valid), 32'd0);
    check("R1 rsp_valid", 32'(host_rsp_valid), 32'd0);
    check("R1 ready", 32'(host_req_ready), 32'd1);
    chk_ctl();
    host_rd(28'h0000000, 0, 0);              // R1 index reads zero
    // R2 R7 R8 raw address cycle, bank 2
    host_wr(28'h0000000, 32'hF_E00_0001);
    host_rd(28'h1230000, 0, 2);              // R2 upper host bits ignored
    host_wr(28'h0000010, 32'h0000_00A5);     // R3
    host_rd(28'h0000010, 3, 1);              // R4
    host_rd(28'h0000010, 0, 0);              // R5 same address streamed
    host_wr(28'h0000010, 32'h5A5A_1234);     // R5
    // R9 other offsets ignored
    host_wr(28'h0000004, 32'hFFFF_FFFF);
    host_rd(28'h0000008, 0, 1);
    host_rd(28'h0000000, 0, 0);
    // map 1 page address
    host_wr(28'h0000000, 32'h0500_0ABC);
    host_rd(28'h0000010, 1, 0);
    // R6 direct mode
    direct_mode = 1'b1;
    host_wr(28'h0000000, 32'h0C00_0002);
    host_rd(28'hABCDE10, 2, 1);
    direct_mode = 1'b0;
    host_rd(28'h0000000, 0, 0);              // R6 index untouched
    for (int i = 0; i < 120; i++) begin
      int op;
      logic [31:0] r;
      op = int'($urandom % 6);
      r = $urandom;
      if (($urandom % 8) == 0) direct_mode = ~direct_mode;
      case (op)
        0: host_wr(28'h0000000, r);
        1: host_wr(28'h0000010, r);
        2: host_rd({r[27:8], 8'h10}, int'($urandom % 5), int'($urandom % 3));
        3: host_rd({r[27:8], 8'h00}, 0, int'($urandom % 3));
        4: host_wr({r[27:8], 8'h20 + 8'((r % 8) * 4)}, $urandom);
        default: host_rd({r[27:8], 8'h24 + 8'((r % 8) * 4)}, int'($urandom % 4), 0);
      endcase
    end
    finish_run();
  end
endmodule